// File: doc/BRIEF.md
# Flash Bus Front End

This block sits between the external pins of an asynchronous byte-wide flash memory and its internal command logic. All pins are sampled on one clock. The three active-low strobes (chip select, read enable, write enable) first pass through a width filter. The filtered strobes are then decoded into a bus operation. Write cycles become a single-cycle pulse that carries the captured address and data. The block also turns the output drivers on and off, runs the sequence that follows the external reset pin, and drives the ready/busy indication. It detects a stable address and enters automatic sleep, and while asleep it holds the output data.

The write pulse is a one-way valid-only stream with no back-pressure. The command logic must take `wr_valid` in the cycle it is high, because the block neither queues nor repeats a cycle. Two pulses are always separated by at least one cycle in which a new write cycle opens. `core_rst` tells the command logic to abandon any operation in progress. `op_busy` tells this block that an embedded program or erase is running.

Top module: `fbus_frontend`

## Requirements
- R1: `bus_op` reports the decoded operation from the filtered strobes: 5 while the reset sequence is active or `ext_rst_n` is low; otherwise 0 with `sel_n` high, 1 for `rden_n` low and `wren_n` high, 2 for `wren_n` low and `rden_n` high, 3 for both high, and 4 for both low.
- R2: A strobe level takes effect only after the new level has been sampled on GLITCH_CYC consecutive clock edges. A shorter pulse has no effect, so a write-enable pulse shorter than that never yields `wr_valid`.
- R3: A write cycle opens on the edge where the filtered select and write-enable are first both seen low, and the address is captured there. It closes on the edge where they are first seen not both low, and `din` is captured there. `wr_valid` is then high for exactly one cycle, with `wr_addr` and `wr_data`.
- R4: A write cycle during which filtered `rden_n` is low at any sampled edge from opening to closing produces no pulse.
- R5: If select and write-enable are low from power-on (`por_n` release), the first write cycle, which ends when they rise, produces no pulse.
- R6: While `ext_rst_n` is low, `dq_oe` is 0, `core_rst` is 1 and no write cycle produces a pulse. After reset release, bus cycles stay ignored until the reset sequence ends.
- R7: The reset sequence starts on the first edge that samples `ext_rst_n` low. It ends on the first edge that samples `ext_rst_n` high after READY_CYC further edges. If `op_busy` was 1 at the start, `dev_ready` is 0 for the whole sequence; otherwise it stays 1.
- R8: Outside the reset sequence, `dev_ready` equals the inverse of `op_busy`.
- R9: `sleep` rises once `addr` has been sampled unchanged on SLEEP_CYC consecutive edges. It falls one edge after `addr` changes, regardless of the strobes.
- R10: `dq_out` loads `arr_data` on every edge where `sleep` is 0 and holds while `sleep` is 1. `dq_oe` is 1 only for a read (R1 code 1) outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External hardware reset pin, active low |
| sel_n | input | 1 | Chip select strobe, active low |
| rden_n | input | 1 | Output (read) enable strobe, active low |
| wren_n | input | 1 | Write enable strobe, active low |
| addr | input | ADDR_W | Address pins |
| din | input | DATA_W | Data pins, input direction |
| arr_data | input | DATA_W | Array data for the current address |
| op_busy | input | 1 | Embedded operation running |
| dq_out | output | DATA_W | Data pins, output value |
| dq_oe | output | 1 | Data pin output enable |
| bus_op | output | 3 | Decoded bus operation code |
| wr_valid | output | 1 | One-cycle write cycle pulse |
| wr_addr | output | ADDR_W | Address of the pulsed write cycle |
| wr_data | output | DATA_W | Data of the pulsed write cycle |
| core_rst | output | 1 | Abort request to the command logic |
| dev_ready | output | 1 | Ready (1) or busy (0) indication |
| sleep | output | 1 | Automatic sleep active |

## Verification
The hardest states to reach from the ports are the power-up inhibit and a reset that lands on a running operation. For the first, the stimulus holds select and write-enable low while `por_n` is still asserted and keeps them low for many cycles after release, so the filtered cycle opens under the inhibit and closes with no pulse. For the second, the stimulus raises `op_busy` before pulling `ext_rst_n` low and then drops it during reset, so only the latched busy state can keep `dev_ready` low up to the end of the READY_CYC window. Sleep-held output is exposed by changing the array contents behind a sleeping address and checking that `dq_out` does not follow.

// File: rtl/fbus_pkg.sv
package fbus_pkg;
  typedef enum logic [2:0] {
    BUS_IDLE  = 3'd0,
    BUS_READ  = 3'd1,
    BUS_WRITE = 3'd2,
    BUS_OFF   = 3'd3,
    BUS_CLASH = 3'd4,
    BUS_RESET = 3'd5
  } bus_op_e;

  localparam int STB_SEL = 0;
  localparam int STB_WR  = 1;
  localparam int STB_RD  = 2;
  localparam int STB_N   = 3;
endpackage

// File: rtl/fbus_deglitch.sv
module fbus_deglitch #(
  parameter int unsigned HOLD = 3,
  parameter bit          INIT = 1'b1
) (
  input  logic clk,
  input  logic por_n,
  input  logic raw,
  output logic filt
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  logic [CW-1:0] run;

  // level moves only after HOLD consecutive differing samples
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      filt <= INIT;
      run  <= '0;
    end else if (raw != filt) begin
      if (run == CW'(HOLD - 1)) begin
        filt <= raw;
        run  <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end else begin
      run <= '0;
    end
  end
endmodule

// File: rtl/fbus_wrcap.sv
module fbus_wrcap #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sel_f,
  input  logic              wr_f,
  input  logic              rd_f,
  input  logic              sel_raw,
  input  logic              wr_raw,
  input  logic              block,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic              both_low;
  logic              both_low_q;
  logic              armed;
  logic              pu_hold;
  logic [ADDR_W-1:0] addr_lat;

  assign both_low = !sel_f && !wr_f;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      both_low_q <= 1'b0;
      armed      <= 1'b0;
      pu_hold    <= 1'b1;
      addr_lat   <= '0;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      both_low_q <= both_low;
      wr_valid   <= 1'b0;
      // power-up inhibit lasts until the raw strobes leave the write level
      if (sel_raw || wr_raw) pu_hold <= 1'b0;
      if (both_low && !both_low_q) begin
        addr_lat <= addr;
        armed    <= rd_f && !pu_hold && !block;
      end else if (both_low) begin
        if (!rd_f || block) armed <= 1'b0;
      end else if (both_low_q) begin
        if (armed && !block) begin
          wr_valid <= 1'b1;
          wr_addr  <= addr_lat;
          wr_data  <= din;
        end
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fbus_rstseq.sv
module fbus_rstseq #(
  parameter int unsigned READY_CYC = 20
) (
  input  logic clk,
  input  logic por_n,
  input  logic ext_rst_n,
  input  logic op_busy,
  output logic seq,
  output logic dev_ready
);
  localparam int unsigned CW = $clog2(READY_CYC + 1);
  logic [CW-1:0] cnt;
  logic          was_busy;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      seq      <= 1'b0;
      cnt      <= '0;
      was_busy <= 1'b0;
    end else if (!seq) begin
      if (!ext_rst_n) begin
        seq      <= 1'b1;
        cnt      <= '0;
        was_busy <= op_busy;
      end
    end else if (cnt < CW'(READY_CYC)) begin
      cnt <= cnt + 1'b1;
    end else if (ext_rst_n) begin
      seq <= 1'b0;
    end
  end

  assign dev_ready = seq ? !was_busy : !op_busy;
endmodule

// File: rtl/fbus_sleep.sv
module fbus_sleep #(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SLEEP_CYC = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] arr_data,
  output logic              sleep,
  output logic [DATA_W-1:0] dq_out
);
  localparam int unsigned CW = $clog2(SLEEP_CYC + 1);
  logic [CW-1:0]     still;
  logic [ADDR_W-1:0] addr_q;

  assign sleep = (still >= CW'(SLEEP_CYC));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      still  <= '0;
      addr_q <= '0;
      dq_out <= '0;
    end else begin
      addr_q <= addr;
      if (addr != addr_q)  still <= '0;
      else if (!sleep)     still <= still + 1'b1;
      if (!sleep) dq_out <= arr_data;
    end
  end
endmodule

// File: rtl/fbus_frontend.sv
module fbus_frontend
  import fbus_pkg::*;
#(
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned GLITCH_CYC = 3,
  parameter int unsigned READY_CYC  = 20,
  parameter int unsigned SLEEP_CYC  = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic              sel_n,
  input  logic              rden_n,
  input  logic              wren_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              op_busy,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [2:0]        bus_op,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              core_rst,
  output logic              dev_ready,
  output logic              sleep
);
  logic [STB_N-1:0] stb_raw;
  logic [STB_N-1:0] stb_f;
  logic             seq;
  logic             blocked;
  bus_op_e          op;

  assign stb_raw[STB_SEL] = sel_n;
  assign stb_raw[STB_WR]  = wren_n;
  assign stb_raw[STB_RD]  = rden_n;

  for (genvar i = 0; i < STB_N; i++) begin : g_flt
    fbus_deglitch #(.HOLD(GLITCH_CYC), .INIT(1'b1)) u_flt (
      .clk(clk), .por_n(por_n), .raw(stb_raw[i]), .filt(stb_f[i])
    );
  end

  assign blocked  = !ext_rst_n || seq;
  assign core_rst = blocked;

  always_comb begin
    if (blocked)                             op = BUS_RESET;
    else if (stb_f[STB_SEL])                 op = BUS_IDLE;
    else if (!stb_f[STB_RD] && stb_f[STB_WR]) op = BUS_READ;
    else if (!stb_f[STB_WR] && stb_f[STB_RD]) op = BUS_WRITE;
    else if (stb_f[STB_WR])                  op = BUS_OFF;
    else                                     op = BUS_CLASH;
  end

  assign bus_op = op;
  assign dq_oe  = (op == BUS_READ);

  fbus_wrcap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wrcap (
    .clk(clk), .por_n(por_n),
    .sel_f(stb_f[STB_SEL]), .wr_f(stb_f[STB_WR]), .rd_f(stb_f[STB_RD]),
    .sel_raw(sel_n), .wr_raw(wren_n), .block(blocked),
    .addr(addr), .din(din),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fbus_rstseq #(.READY_CYC(READY_CYC)) u_rstseq (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .op_busy(op_busy),
    .seq(seq), .dev_ready(dev_ready)
  );

  fbus_sleep #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLEEP_CYC(SLEEP_CYC)) u_sleep (
    .clk(clk), .por_n(por_n), .addr(addr), .arr_data(arr_data),
    .sleep(sleep), .dq_out(dq_out)
  );
endmodule

// File: rtl/fbus_frontend_chk.sv
module fbus_frontend_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              por_n,
  input logic              ext_rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_valid,
  input logic [2:0]        bus_op,
  input logic              dev_ready,
  input logic              sleep,
  input logic [DATA_W-1:0] dq_out
);
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
    wr_valid |=> !wr_valid); // R3

  AST_RESET_HOLDS_OFF: assert property (@(posedge clk) disable iff (!por_n)
    ($past(por_n) && $past(!ext_rst_n)) |-> (bus_op == 3'd5 && !wr_valid)); // R6

  AST_READY_STAYS_UP: assert property (@(posedge clk) disable iff (!por_n)
    ($past(por_n) && !ext_rst_n && $past(!ext_rst_n) && dev_ready) |=> dev_ready); // R7

  AST_SLEEP_AFTER_STABLE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sleep) |-> ($past(addr) == $past(addr, 2))); // R9

  AST_DQ_HELD_ASLEEP: assert property (@(posedge clk) disable iff (!por_n)
    ($past(por_n) && $past(sleep)) |-> $stable(dq_out)); // R10
endmodule

bind fbus_frontend fbus_frontend_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .addr(addr),
  .wr_valid(wr_valid), .bus_op(bus_op), .dev_ready(dev_ready),
  .sleep(sleep), .dq_out(dq_out)
);

// File: tb/test_fbus_frontend.sv
module test_fbus_frontend;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int G  = 3;
  localparam int RC = 20;
  localparam int SC = 8;

  logic clk = 1'b0;
  logic por_n, ext_rst_n, sel_n, rden_n, wren_n, op_busy;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, key, arr_data;
  logic [DW-1:0] dq_out, wr_data;
  logic [AW-1:0] wr_addr;
  logic dq_oe, wr_valid, core_rst, dev_ready, sleep;
  logic [2:0] bus_op;

  int n_chk = 0;
  int n_bad = 0;
  int n_puls = 0;
  logic [AW-1:0] last_a;
  logic [DW-1:0] last_d;

  assign arr_data = addr[DW-1:0] ^ key;

  always #10 clk = ~clk;

  fbus_frontend #(.ADDR_W(AW), .DATA_W(DW), .GLITCH_CYC(G), .READY_CYC(RC), .SLEEP_CYC(SC))
  i_fbus_frontend (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .sel_n(sel_n), .rden_n(rden_n),
    .wren_n(wren_n), .addr(addr), .din(din), .arr_data(arr_data), .op_busy(op_busy),
    .dq_out(dq_out), .dq_oe(dq_oe), .bus_op(bus_op), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .core_rst(core_rst),
    .dev_ready(dev_ready), .sleep(sleep)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int   m_run [3];
  logic m_lvl [3];     // 0 sel, 1 wr, 2 rd (high = inactive)
  logic m_open, m_arm, m_pu, m_seq, m_wb, m_valid;
  int   m_cnt, m_still;
  logic [AW-1:0] m_alat, m_addr, m_prev;
  logic [DW-1:0] m_data, m_dq;

  always @(posedge clk) begin
    if (!por_n) begin
      for (int i = 0; i < 3; i++) begin m_run[i] = 0; m_lvl[i] = 1'b1; end
      m_open = 0; m_arm = 0; m_pu = 1; m_seq = 0; m_wb = 0; m_valid = 0;
      m_cnt = 0; m_still = 0; m_alat = '0; m_addr = '0; m_data = '0;
      m_prev = '0; m_dq = '0;
    end else begin
      logic blk, low2, sleeping;
      logic raw [3];
      raw[0] = sel_n; raw[1] = wren_n; raw[2] = rden_n;
      blk  = !ext_rst_n || m_seq;
      low2 = !m_lvl[0] && !m_lvl[1];
      m_valid = 0;
      if (low2 && !m_open) begin
        m_alat = addr;
        m_arm  = m_lvl[2] && !m_pu && !blk;
      end else if (low2) begin
        if (!m_lvl[2] || blk) m_arm = 0;
      end else if (m_open) begin
        if (m_arm && !blk) begin m_valid = 1; m_addr = m_alat; m_data = din; end
        m_arm = 0;
      end
      m_open = low2;
      if (sel_n || wren_n) m_pu = 0;
      for (int i = 0; i < 3; i++) begin
        if (raw[i] != m_lvl[i]) begin
          m_run[i]++;
          if (m_run[i] >= G) begin m_lvl[i] = raw[i]; m_run[i] = 0; end
        end else m_run[i] = 0;
      end
      if (!m_seq) begin
        if (!ext_rst_n) begin m_seq = 1; m_cnt = 0; m_wb = op_busy; end
      end else if (m_cnt < RC) m_cnt++;
      else if (ext_rst_n) m_seq = 0;
      sleeping = (m_still >= SC);
      if (!sleeping) m_dq = arr_data;
      if (addr != m_prev) m_still = 0;
      else if (!sleeping) m_still++;
      m_prev = addr;
    end
  end

  function automatic logic [2:0] exp_op();
    if (!ext_rst_n || m_seq) return 3'd5;
    if (m_lvl[0]) return 3'd0;
    if (!m_lvl[2] && m_lvl[1]) return 3'd1;
    if (!m_lvl[1] && m_lvl[2]) return 3'd2;
    if (m_lvl[1]) return 3'd3;
    return 3'd4;
  endfunction

  always @(negedge clk) begin
    if (por_n) begin
      logic [2:0] eo;
      eo = exp_op();
      check("R1 bus_op", 32'(bus_op), 32'(eo));
      check("R3 wr_valid", 32'(wr_valid), 32'(m_valid));
      if (m_valid) begin
        check("R3 wr_addr", 32'(wr_addr), 32'(m_addr));
        check("R3 wr_data", 32'(wr_data), 32'(m_data));
      end
      check("R6 core_rst", 32'(core_rst), 32'(!ext_rst_n || m_seq));
      check("R7 dev_ready", 32'(dev_ready), 32'(m_seq ? !m_wb : !op_busy));
      check("R9 sleep", 32'(sleep), 32'(m_still >= SC));
      check("R10 dq_oe", 32'(dq_oe), 32'(eo == 3'd1));
      check("R10 dq_out", 32'(dq_out), 32'(m_dq));
      if (wr_valid) begin n_puls++; last_a = wr_addr; last_d = wr_data; end
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit we_first);
    addr = a; din = d;
    if (we_first) wren_n = 0; else sel_n = 0;
    tick(1);
    if (we_first) sel_n = 0; else wren_n = 0;
    tick(G + 3);
    if (we_first) sel_n = 1; else wren_n = 1;
    tick(1);
    if (we_first) wren_n = 1; else sel_n = 1;
    tick(G + 4);
  endtask

  initial begin
    int base;
    por_n = 0; ext_rst_n = 1; sel_n = 0; wren_n = 0; rden_n = 1;
    op_busy = 0; addr = '0; din = '0; key = '0;
    tick(3);
    por_n = 1;
    @(negedge clk);
    check("R3 reset wr_valid", 32'(wr_valid), 32'd0);
    check("R8 reset ready", 32'(dev_ready), 32'd1);
    check("R6 reset core_rst", 32'(core_rst), 32'd0);
    tick(10);
    wren_n = 1; tick(1); sel_n = 1; tick(G + 5);
    check("R5 power-up cycle ignored", 32'(n_puls), 32'd0);

    do_write(19'h12345, 8'hA7, 1'b0);
    check("R3 pulse count", 32'(n_puls), 32'd1);
    check("R3 address", 32'(last_a), 32'h12345);
    check("R3 data", 32'(last_d), 32'hA7);
    do_write(19'h0ABCD, 8'h3C, 1'b1);
    check("R3 pulse count swapped order", 32'(n_puls), 32'd2);
    check("R3 address swapped order", 32'(last_a), 32'h0ABCD);
    check("R3 data swapped order", 32'(last_d), 32'h3C);

    base = n_puls;
    sel_n = 0; tick(G + 2); wren_n = 0; tick(G - 1); wren_n = 1; tick(2); sel_n = 1; tick(G + 4);
    check("R2 short pulse ignored", 32'(n_puls), 32'(base));

    rden_n = 0; sel_n = 0; wren_n = 0; tick(G + 4);
    wren_n = 1; sel_n = 1; tick(1); rden_n = 1; tick(G + 4);
    check("R4 read enable low inhibits", 32'(n_puls), 32'(base));

    addr = 19'h00033; sel_n = 0; rden_n = 0; tick(G + 3);
    @(negedge clk);
    check("R10 read drives", 32'(dq_oe), 32'd1);
    check("R10 read data", 32'(dq_out), 32'h33);
    tick(SC + 4);
    check("R9 asleep after stable address", 32'(sleep), 32'd1);
    key = 8'hFF; tick(3);
    check("R10 data held while asleep", 32'(dq_out), 32'h33);
    addr = 19'h00034; tick(1);
    check("R9 wake on address change", 32'(sleep), 32'd0);
    tick(2);
    check("R10 data follows after wake", 32'(dq_out), 32'(8'h34 ^ 8'hFF));

    op_busy = 1; tick(1);
    check("R8 busy passes through", 32'(dev_ready), 32'd0);
    op_busy = 0; tick(1);

    ext_rst_n = 0; tick(1);
    check("R6 outputs off in reset", 32'(dq_oe), 32'd0);
    check("R6 abort raised", 32'(core_rst), 32'd1);
    check("R7 idle reset keeps ready", 32'(dev_ready), 32'd1);
    rden_n = 1; sel_n = 0; wren_n = 0; tick(G + 3); wren_n = 1; tick(G + 3);
    check("R6 write ignored in reset", 32'(n_puls), 32'(base));
    ext_rst_n = 1; tick(RC + 4);
    check("R7 idle reset ready", 32'(dev_ready), 32'd1);
    sel_n = 1; tick(G + 3);

    op_busy = 1; tick(2);
    ext_rst_n = 0; tick(3);
    op_busy = 0; tick(1);
    check("R7 busy reset holds busy", 32'(dev_ready), 32'd0);
    tick(2); ext_rst_n = 1; tick(5);
    check("R7 busy after release", 32'(dev_ready), 32'd0);
    tick(RC + 4);
    check("R7 ready after sequence", 32'(dev_ready), 32'd1);
    check("R6 abort cleared", 32'(core_rst), 32'd0);

    do_write(19'h7FFFF, 8'h01, 1'b0);
    check("R3 write after reset", 32'(n_puls), 32'(base + 1));
    check("R3 address after reset", 32'(last_a), 32'h7FFFF);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule